// File: doc/BRIEF.md
# Bus Cycle Length Controller

This block decides how many bus clock periods each bus access lasts. When a request is accepted, it classifies the access address into one of four classes: the register window at the bottom of the map, internal RAM, internal ROM, or external space. For external space it picks the settings of the selected chip select. From the class, a global wait bit, a per-chip-select wait bit and a per-chip-select bus type (separate or multiplexed address/data), it derives a planned length of one to three periods. External accesses can then be stretched further, one period at a time, by a ready input.

The request side is a valid/ready handshake. A request is taken on a rising edge where `req_valid` is high and `req_ready` is high. `req_ready` is low for as long as a cycle is in progress. A requester that sees `req_ready` low keeps its request pending, and nothing it drives during that time affects the cycle already running. `bus_strobe` and `busy` are high for every period of the accepted cycle. `cycle_done` pulses in its final period.

Top module: `bus_wait_ctrl`

## Requirements
- R1: After reset `busy`, `bus_strobe` and `cycle_done` are low and `req_ready` is high.
- R2: A request is accepted on a rising edge with `req_valid` high and `busy` low. `busy` and `bus_strobe` are high from the next period through the period in which `cycle_done` pulses once. `busy` is low in the period after that.
- R3: An address from 0 to `SFR_END` takes 2 periods, whatever the wait bits.
- R4: An address in internal RAM (`RAM_BASE`..`RAM_END`) or internal ROM (`ROM_BASE`..`ROM_END`) takes 1 period when `cfg_wait_all` is 0 and 2 when it is 1. `ext_rdy` has no effect on these accesses.
- R5: An external access on a separate bus (`cfg_cs_mux[i]`=0) takes 2 periods with wait enabled and 1 without.
- R6: An external access on a multiplexed bus (`cfg_cs_mux[i]`=1) takes 3 periods with wait enabled and 2 without.
- R7: Wait is enabled for chip select i when `cfg_cs_wait[i]`=1 or when `cfg_wait_all`=1. The global bit overrides a cleared per-chip-select bit.
- R8: An external address with `cs_valid` low uses the settings of chip select 0, whatever `cs_sel` holds.
- R9: For external accesses, `ext_rdy` is sampled in the last planned period and in each period after it. Every period in which it is low adds one period. `cycle_done` pulses in the first period where it is high.
- R10: Changes to address, chip select and configuration after acceptance have no effect on the running cycle. `req_valid` held high while `busy` is high starts no further cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | High when a request can be accepted |
| req_addr | input | ADDR_W | Access address |
| req_write | input | 1 | Access direction (1 = write), no effect on length |
| cs_valid | input | 1 | External chip select decode is valid |
| cs_sel | input | CS_W | Selected chip select index |
| cfg_wait_all | input | 1 | Global wait enable |
| cfg_cs_wait | input | N_CS | Per-chip-select wait enable, bit i for chip select i |
| cfg_cs_mux | input | N_CS | Per-chip-select bus type, 1 = multiplexed |
| ext_rdy | input | 1 | External ready, low stretches an external cycle |
| bus_strobe | output | 1 | High during every period of a bus cycle |
| cycle_done | output | 1 | One-period pulse in the final period of a cycle |
| busy | output | 1 | Cycle in progress |

## Verification
Two functions meet in the last planned period of an external access: the planned count expires and the ready sample decides whether the cycle ends. The bench holds `ext_rdy` low across that period for zero to four extra periods and expects the total length to be exactly planned plus extra. Acceptance and reconfiguration also meet: the bench scrambles address, chip select and every wait and bus-type bit in the period right after acceptance while keeping `req_valid` high. It expects the originally planned length and no second cycle.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  typedef enum logic [1:0] {
    RG_SFR  = 2'd0,
    RG_IRAM = 2'd1,
    RG_IROM = 2'd2,
    RG_EXT  = 2'd3
  } region_e;
endpackage

// File: rtl/bwc_region_dec.sv
module bwc_region_dec
  import bwc_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int SFR_END  = 'h003FF,
  parameter int RAM_BASE = 'h00400,
  parameter int RAM_END  = 'h02BFF,
  parameter int ROM_BASE = 'hE8000,
  parameter int ROM_END  = 'hFFFFF
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region
);
  localparam logic [ADDR_W-1:0] SFR_HI = ADDR_W'(SFR_END);
  localparam logic [ADDR_W-1:0] RAM_LO = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] RAM_HI = ADDR_W'(RAM_END);
  localparam logic [ADDR_W-1:0] ROM_LO = ADDR_W'(ROM_BASE);
  localparam logic [ADDR_W-1:0] ROM_HI = ADDR_W'(ROM_END);

  always_comb begin
    if (addr <= SFR_HI)                        region = RG_SFR;
    else if (addr >= RAM_LO && addr <= RAM_HI) region = RG_IRAM;
    else if (addr >= ROM_LO && addr <= ROM_HI) region = RG_IROM;
    else                                       region = RG_EXT;
  end
endmodule

// File: rtl/bwc_len_calc.sv
module bwc_len_calc
  import bwc_pkg::*;
#(
  parameter int N_CS  = 4,
  parameter int CS_W  = 2,
  parameter int LEN_W = 2
) (
  input  region_e          region,
  input  logic             cs_valid,
  input  logic [CS_W-1:0]  cs_sel,
  input  logic             wait_all,
  input  logic [N_CS-1:0]  cs_wait,
  input  logic [N_CS-1:0]  cs_mux,
  output logic [LEN_W-1:0] plan_len,
  output logic             ext_acc
);
  logic [N_CS-1:0] wait_en;
  logic [CS_W-1:0] idx;
  logic            sel_wait;
  logic            sel_mux;

  for (genvar g = 0; g < N_CS; g++) begin : g_wen
    assign wait_en[g] = wait_all | cs_wait[g];
  end

  always_comb begin
    idx      = cs_valid ? cs_sel : '0;
    sel_wait = wait_en[idx];
    sel_mux  = cs_mux[idx];
    ext_acc  = (region == RG_EXT);
    unique case (region)
      RG_SFR:  plan_len = LEN_W'(2);
      RG_IRAM,
      RG_IROM: plan_len = wait_all ? LEN_W'(2) : LEN_W'(1);
      default: begin
        if (sel_mux) plan_len = sel_wait ? LEN_W'(3) : LEN_W'(2);
        else         plan_len = sel_wait ? LEN_W'(2) : LEN_W'(1);
      end
    endcase
  end
endmodule

// File: rtl/bwc_seq.sv
module bwc_seq #(
  parameter int LEN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LEN_W-1:0] plan_len,
  input  logic             ext_acc,
  input  logic             rdy,
  output logic             active,
  output logic             done
);
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len_q;
  logic             ext_q;
  logic             at_last;

  assign at_last = active && (cnt == len_q);
  assign done    = at_last && (!ext_q || rdy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      len_q  <= '0;
      ext_q  <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= LEN_W'(1);
      len_q  <= plan_len;
      ext_q  <= ext_acc;
    end else if (active) begin
      if (done)               active <= 1'b0;
      else if (cnt != len_q)  cnt    <= cnt + LEN_W'(1);
    end
  end

  // R9
  rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_last && ext_q && !rdy) |=> (active && at_last));

  // R10
  len_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !done) |=> ($stable(len_q) && $stable(ext_q)));

  // R2
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !active);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt >= LEN_W'(1) && cnt <= len_q));
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
  import bwc_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int N_CS     = 4,
  parameter int SFR_END  = 'h003FF,
  parameter int RAM_BASE = 'h00400,
  parameter int RAM_END  = 'h02BFF,
  parameter int ROM_BASE = 'hE8000,
  parameter int ROM_END  = 'hFFFFF,
  localparam int CS_W    = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              cs_valid,
  input  logic [CS_W-1:0]   cs_sel,
  input  logic              cfg_wait_all,
  input  logic [N_CS-1:0]   cfg_cs_wait,
  input  logic [N_CS-1:0]   cfg_cs_mux,
  input  logic              ext_rdy,
  output logic              bus_strobe,
  output logic              cycle_done,
  output logic              busy
);
  localparam int MAX_LEN = 3;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  region_e          region;
  logic [LEN_W-1:0] plan_len;
  logic             ext_acc;
  logic             active;
  logic             start;
  logic             unused_write;

  assign unused_write = req_write;
  assign start        = req_valid && !active;
  assign req_ready    = !active;
  assign busy         = active;
  assign bus_strobe   = active;

  bwc_region_dec #(
    .ADDR_W(ADDR_W), .SFR_END(SFR_END), .RAM_BASE(RAM_BASE),
    .RAM_END(RAM_END), .ROM_BASE(ROM_BASE), .ROM_END(ROM_END)
  ) u_dec (
    .addr   (req_addr),
    .region (region)
  );

  bwc_len_calc #(.N_CS(N_CS), .CS_W(CS_W), .LEN_W(LEN_W)) u_len (
    .region   (region),
    .cs_valid (cs_valid),
    .cs_sel   (cs_sel),
    .wait_all (cfg_wait_all),
    .cs_wait  (cfg_cs_wait),
    .cs_mux   (cfg_cs_mux),
    .plan_len (plan_len),
    .ext_acc  (ext_acc)
  );

  bwc_seq #(.LEN_W(LEN_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .plan_len (plan_len),
    .ext_acc  (ext_acc),
    .rdy      (ext_rdy),
    .active   (active),
    .done     (cycle_done)
  );

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (busy && bus_strobe));

  // R3
  sfr_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && region == RG_SFR) |-> (plan_len == LEN_W'(2)));

  // R2
  done_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |-> busy);
endmodule

// File: tb/sim_bus_wait_ctrl.sv
`timescale 1ns/1ps
module sim_bus_wait_ctrl;
  localparam int ADDR_W = 20;
  localparam int N_CS   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_write = 1'b0;
  logic cs_valid = 1'b0;
  logic [1:0] cs_sel = '0;
  logic cfg_wait_all = 1'b0;
  logic [N_CS-1:0] cfg_cs_wait = '0;
  logic [N_CS-1:0] cfg_cs_mux = '0;
  logic ext_rdy = 1'b1;
  logic bus_strobe, cycle_done, busy;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  int q_len[$];
  string q_tag[$];
  int run_cnt = 0;

  always #2 clk = ~clk;

  bus_wait_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .cs_valid(cs_valid),
    .cs_sel(cs_sel), .cfg_wait_all(cfg_wait_all), .cfg_cs_wait(cfg_cs_wait),
    .cfg_cs_mux(cfg_cs_mux), .ext_rdy(ext_rdy), .bus_strobe(bus_strobe),
    .cycle_done(cycle_done), .busy(busy)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int region_of(input logic [ADDR_W-1:0] a);
    if (a <= 20'h003FF) return 0;
    if (a >= 20'h00400 && a <= 20'h02BFF) return 1;
    if (a >= 20'hE8000) return 2;
    return 3;
  endfunction

  function automatic int planned(input logic [ADDR_W-1:0] a, input bit cv,
      input int cs, input bit wall, input logic [3:0] wb, input logic [3:0] mb);
    int r, i;
    bit w;
    r = region_of(a);
    if (r == 0) return 2;
    if (r != 3) return wall ? 2 : 1;
    i = cv ? cs : 0;
    w = wall | wb[i];
    if (mb[i]) return w ? 3 : 2;
    return w ? 2 : 1;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_strobe) run_cnt++;
      if (cycle_done) begin
        if (q_len.size() == 0) begin
          check(0, "R10 unexpected cycle", run_cnt, 0);
        end else begin
          int e;
          string t;
          e = q_len.pop_front();
          t = q_tag.pop_front();
          check(run_cnt == e, t, run_cnt, e);
          check(busy && !req_ready, "R2 busy in done period", busy, 1);
        end
        run_cnt = 0;
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_req(input logic [ADDR_W-1:0] a, input bit cv, input int cs,
      input bit wall, input logic [3:0] wb, input logic [3:0] mb,
      input int extra, input bit scramble, input string tag);
    int base, total, cyc;
    bit ext;
    while (busy) step();
    base  = planned(a, cv, cs, wall, wb, mb);
    ext   = (region_of(a) == 3);
    total = ext ? base + extra : base;
    q_len.push_back(total);
    q_tag.push_back(tag);
    req_addr = a; cs_valid = cv; cs_sel = 2'(cs);
    cfg_wait_all = wall; cfg_cs_wait = wb; cfg_cs_mux = mb;
    req_write = ~req_write;
    ext_rdy = (extra == 0);
    req_valid = 1'b1;
    step();
    cyc = 1;
    if (!scramble) req_valid = 1'b0;
    else begin
      req_addr = 20'h00010; cs_valid = ~cv; cs_sel = ~cs_sel;
      cfg_wait_all = ~wall; cfg_cs_wait = ~wb; cfg_cs_mux = ~mb;
    end
    if (cyc >= base + extra) ext_rdy = 1'b1;
    while (cyc < total) begin
      step();
      cyc++;
      if (cyc >= base + extra) ext_rdy = 1'b1;
    end
    req_valid = 1'b0;
    ext_rdy = 1'b1;
    step();
    check(!busy && req_ready, {tag, " R2 idle after done"}, busy, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1;
    repeat (3) step();
    check(!busy && !bus_strobe && !cycle_done && req_ready, "R1 reset state", busy, 0);
    rst_n = 1'b1;
    step();
    check(!busy && !bus_strobe && !cycle_done && req_ready, "R1 after release", busy, 0);

    do_req(20'h00010, 0, 0, 0, 4'h0, 4'h0, 0, 0, "R3 sfr no wait");
    do_req(20'h003FF, 0, 0, 1, 4'hF, 4'hF, 0, 0, "R3 sfr wait all");
    do_req(20'h00500, 0, 0, 0, 4'hF, 4'hF, 0, 0, "R4 ram");
    do_req(20'h02BFF, 0, 0, 1, 4'h0, 4'h0, 0, 0, "R4 ram wait all");
    do_req(20'hF0000, 0, 0, 0, 4'hF, 4'hF, 0, 0, "R4 rom");
    do_req(20'hE8000, 0, 0, 1, 4'h0, 4'h0, 0, 0, "R4 rom wait all");
    do_req(20'hFFFFF, 0, 0, 0, 4'h0, 4'h0, 3, 0, "R4 rom ready ignored");
    do_req(20'h10000, 1, 1, 0, 4'h0, 4'h0, 0, 0, "R5 sep no wait");
    do_req(20'h10000, 1, 1, 0, 4'h2, 4'h0, 0, 0, "R5 sep wait");
    do_req(20'h20000, 1, 2, 0, 4'h4, 4'h4, 0, 0, "R6 mux wait");
    do_req(20'h20000, 1, 2, 0, 4'hB, 4'h4, 0, 0, "R6 mux no wait");
    do_req(20'h30000, 1, 3, 1, 4'h0, 4'h0, 0, 0, "R7 global sep");
    do_req(20'h30000, 1, 3, 1, 4'h0, 4'h8, 0, 0, "R7 global mux");
    do_req(20'h40000, 0, 3, 0, 4'h1, 4'h1, 0, 0, "R8 default cs0 mux wait");
    do_req(20'h40000, 0, 2, 0, 4'h4, 4'h4, 0, 0, "R8 default cs0 plain");
    do_req(20'h10000, 1, 1, 0, 4'h2, 4'h0, 2, 0, "R9 sep wait ready low");
    do_req(20'h20000, 1, 2, 0, 4'h4, 4'h4, 1, 0, "R9 mux wait ready low");
    do_req(20'h50000, 1, 0, 0, 4'h0, 4'h0, 4, 0, "R9 no wait ready low");
    do_req(20'h10000, 1, 1, 0, 4'h0, 4'h0, 0, 1, "R10 scramble short");
    do_req(20'h20000, 1, 2, 0, 4'h4, 4'h4, 0, 1, "R10 scramble long");
    do_req(20'h20000, 1, 2, 1, 4'h0, 4'h4, 2, 1, "R10 scramble with ready");

    repeat (3) step();
    check(q_len.size() == 0, "R2 all cycles completed", q_len.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule